// File: doc/BRIEF.md
# SPI Command to Register Bridge

This block is the command engine between a memory-mapped SPI slave core and a shared register bus that serves six UART controllers. It polls the SPI core until a 32-bit command word has arrived, fetches and decodes that word, and then acts on the UART bus. The action is a register write, a single register read, a continuous receive-FIFO read, or a read of the per-port data-available flags. Every read-type result is packed into a framed 32-bit response and written to the SPI core's transmit register, so the host shifts it out during its next transfer.

The command word splits into four fields. An opcode sits in bits [31:30], a 12-bit address in [27:16], and write data in [15:0]. For read-type commands the low byte [7:0] selects the subtype. Every response carries a constant lead code in its top 14 bits, so the host can find the word boundary even when the word arrives shifted by a bit or two. Both buses use the same master handshake: a request is held while waitrequest is high, and read data arrives later with readdatavalid.

Top module: `spi_cmd_bridge`

## Requirements
- R1: After reset and after each command, the bridge spends exactly 2 cycles with no bus activity. It then reads the SPI status register at offset 2, repeating until bit 7 (receive ready) is 1, and only then reads the received word at offset 0. All strobes are low during reset.
- R2: A bus request keeps its address, data and strobe unchanged while waitrequest is high, and never asserts read and write together. Read data is taken in the cycle readdatavalid is high.
- R3: Opcode 01 in [31:30] issues one UART write, to address [27:16] with data [15:0]. It causes no SPI write, and the bridge then returns to idle.
- R4: Opcode 10 with subtype 0x00 in [7:0] reads UART address [27:16] and returns the 16-bit read data as payload. Bits [15:8] of the command have no effect.
- R5: A response is written to SPI offset 1. It holds 0x2000 in [31:18], the 16-bit payload in [17:2], and 0 in [1:0].
- R6: Subtype 0xFF returns the port data-available inputs in payload bits [5:0], which are response bits [7:2], with the other payload bits zero.
- R7: Subtype 0xFE selects port [27:25] and reads the line status register at window base + 0x14, where each port's window base is port × 0x200. If bit 0 is 1, the bridge reads the receive register at base + 0 and returns the payload {1, data[14:0]}. If bit 0 is 0, it returns payload 0 without reading the receive register. Address bits [24:16] have no effect.
- R8: Subtype 0xFD makes no UART access and no SPI write; the pending response stays in place.
- R9: Any other subtype under opcode 10 returns a response with zero payload.
- R10: Opcodes 00 and 11 are ignored: no UART access and no SPI write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| spi_addr_o | output | SPI_AW | SPI core register offset |
| spi_rd_o | output | 1 | SPI core read strobe |
| spi_wr_o | output | 1 | SPI core write strobe |
| spi_wdata_o | output | 32 | Response word to SPI core |
| spi_rdata_i | input | 32 | SPI core read data |
| spi_wait_i | input | 1 | SPI core waitrequest |
| spi_rvalid_i | input | 1 | SPI core read data valid |
| uart_addr_o | output | 12 | UART bus address |
| uart_rd_o | output | 1 | UART bus read strobe |
| uart_wr_o | output | 1 | UART bus write strobe |
| uart_wdata_o | output | 16 | UART bus write data |
| uart_rdata_i | input | 16 | UART bus read data |
| uart_wait_i | input | 1 | UART bus waitrequest |
| uart_rvalid_i | input | 1 | UART bus read data valid |
| port_avail_i | input | NPORTS | Per-port data-available flags |

## Verification
A table of command words covers each opcode and subtype.

- Writes go to an inner and a top-of-window address, so the address and data fields are shown to pass through intact.
- The register read is tried with and without junk in bits [15:8], which shows that only the low byte selects the subtype.
- Continuous reads target a port whose line status reports data, a port whose line status reports none, and a command with junk in the ignored address bits. Together these separate the valid-flag path, the empty path and the port selection, and the count of UART reads confirms that an empty FIFO is never drained.
- Dummy, unknown-subtype and undefined-opcode words show the difference between silence and a lead-code-only reply.
- Alternate vectors run with one waitrequest cycle per access, which exercises the hold behaviour.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  localparam int CMD_W  = 32;
  localparam int UA_W   = 12;
  localparam int UD_W   = 16;
  localparam int LEAD_W = 14;
  localparam logic [LEAD_W-1:0] LEAD_CODE = 14'h2000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_POLL, ST_FETCH, ST_DECODE, ST_UWRITE,
    ST_UREAD, ST_LSR, ST_FIFO, ST_PACK, ST_SPIWR
  } state_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WRITE, CMD_READ, CMD_DUMMY, CMD_STREAM, CMD_STATUS, CMD_BAD
  } cmd_e;

  // Frame a 16-bit payload with the lead code and two zero pad bits
  function automatic logic [CMD_W-1:0] frame_resp(input logic [UD_W-1:0] p);
    return {LEAD_CODE, p, 2'b00};
  endfunction

  // Port window address: 0x200 per port plus an in-window offset
  function automatic logic [UA_W-1:0] win_addr(input logic [2:0] port,
                                               input logic [8:0] ofs);
    return {port, ofs};
  endfunction

  // Continuous-read payload: valid flag on top of 15 data bits
  function automatic logic [UD_W-1:0] stream_payload(input logic ok,
                                                     input logic [UD_W-1:0] d);
    return ok ? {1'b1, d[14:0]} : '0;
  endfunction

endpackage

// File: rtl/bridge_cmd_decode.sv
module bridge_cmd_decode
  import bridge_pkg::*;
#(
  parameter logic [7:0] SUB_READ   = 8'h00,
  parameter logic [7:0] SUB_DUMMY  = 8'hFD,
  parameter logic [7:0] SUB_STREAM = 8'hFE,
  parameter logic [7:0] SUB_STATUS = 8'hFF
) (
  input  logic [CMD_W-1:0] word_i,
  output cmd_e             kind_o,
  output logic [UA_W-1:0]  addr_o,
  output logic [UD_W-1:0]  data_o,
  output logic [2:0]       port_o
);
  logic unused_gap;
  assign unused_gap = ^word_i[29:28];

  assign addr_o = word_i[27:16];
  assign data_o = word_i[15:0];
  assign port_o = word_i[27:25];

  always_comb begin
    unique case (word_i[31:30])
      2'b01: kind_o = CMD_WRITE;
      2'b10: begin
        if (word_i[7:0] == SUB_READ)        kind_o = CMD_READ;
        else if (word_i[7:0] == SUB_DUMMY)  kind_o = CMD_DUMMY;
        else if (word_i[7:0] == SUB_STREAM) kind_o = CMD_STREAM;
        else if (word_i[7:0] == SUB_STATUS) kind_o = CMD_STATUS;
        else                                kind_o = CMD_BAD;
      end
      default: kind_o = CMD_NONE;
    endcase
  end
endmodule

// File: rtl/bridge_bus_master.sv
module bridge_bus_master #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          req_wr_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_wait_i,
  input  logic          bus_rvalid_i
);
  typedef enum logic [1:0] {M_IDLE, M_REQ, M_RESP} phase_e;
  phase_e ph;

  // Completion: write accepted, or read data returned
  wire wr_accept = (ph == M_REQ) && bus_wr_o && !bus_wait_i;
  wire rd_return = (ph == M_RESP) && bus_rvalid_i;
  assign done_o  = wr_accept || rd_return;
  assign rdata_o = bus_rdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= M_IDLE;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      bus_rd_o    <= 1'b0;
      bus_wr_o    <= 1'b0;
    end else begin
      unique case (ph)
        M_IDLE: if (req_i) begin
          bus_addr_o  <= req_addr_i;
          bus_wdata_o <= req_wdata_i;
          bus_wr_o    <= req_wr_i;
          bus_rd_o    <= !req_wr_i;
          ph          <= M_REQ;
        end
        M_REQ: if (!bus_wait_i) begin
          bus_rd_o <= 1'b0;
          bus_wr_o <= 1'b0;
          ph       <= bus_wr_o ? M_IDLE : M_RESP;
        end
        M_RESP: if (bus_rvalid_i) ph <= M_IDLE;
        default: ph <= M_IDLE;
      endcase
    end
  end

  // R2: request held steady while the slave stalls
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd_o || bus_wr_o) && bus_wait_i) |=>
      ($stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_rd_o) && $stable(bus_wr_o)));

  // R2: never read and write at once
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_o && bus_wr_o));
endmodule

// File: rtl/spi_cmd_bridge.sv
module spi_cmd_bridge
  import bridge_pkg::*;
#(
  parameter int         NPORTS     = 6,
  parameter int         IDLE_CYC   = 2,
  parameter int         SPI_AW     = 3,
  parameter logic [2:0] SPI_RX_OFS = 3'd0,
  parameter logic [2:0] SPI_TX_OFS = 3'd1,
  parameter logic [2:0] SPI_ST_OFS = 3'd2,
  parameter int         RRDY_BIT   = 7,
  parameter logic [8:0] LSR_OFS    = 9'h014,
  parameter logic [8:0] RXD_OFS    = 9'h000,
  parameter int         DR_BIT     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SPI_AW-1:0] spi_addr_o,
  output logic              spi_rd_o,
  output logic              spi_wr_o,
  output logic [31:0]       spi_wdata_o,
  input  logic [31:0]       spi_rdata_i,
  input  logic              spi_wait_i,
  input  logic              spi_rvalid_i,
  output logic [11:0]       uart_addr_o,
  output logic              uart_rd_o,
  output logic              uart_wr_o,
  output logic [15:0]       uart_wdata_o,
  input  logic [15:0]       uart_rdata_i,
  input  logic              uart_wait_i,
  input  logic              uart_rvalid_i,
  input  logic [NPORTS-1:0] port_avail_i
);
  localparam int IDLE_W = $clog2(IDLE_CYC + 1);

  state_e              state;
  logic [IDLE_W-1:0]   idle_cnt;
  logic [CMD_W-1:0]    cmd_q, resp_q;
  logic [UD_W-1:0]     fifo_q;

  cmd_e                dec_kind;
  logic [UA_W-1:0]     dec_addr;
  logic [UD_W-1:0]     dec_data;
  logic [2:0]          dec_port;

  logic                spi_req, spi_req_wr, spi_done;
  logic [SPI_AW-1:0]   spi_req_addr;
  logic [CMD_W-1:0]    spi_rdata;
  logic                u_req, u_req_wr, u_done;
  logic [UA_W-1:0]     u_req_addr;
  logic [UD_W-1:0]     u_req_wdata, u_rdata;

  bridge_cmd_decode dec_i (
    .word_i (cmd_q), .kind_o (dec_kind), .addr_o (dec_addr),
    .data_o (dec_data), .port_o (dec_port)
  );

  bridge_bus_master #(.AW(SPI_AW), .DW(CMD_W)) spi_m_i (
    .clk, .rst_n,
    .req_i (spi_req), .req_wr_i (spi_req_wr), .req_addr_i (spi_req_addr),
    .req_wdata_i (resp_q), .done_o (spi_done), .rdata_o (spi_rdata),
    .bus_addr_o (spi_addr_o), .bus_rd_o (spi_rd_o), .bus_wr_o (spi_wr_o),
    .bus_wdata_o (spi_wdata_o), .bus_rdata_i (spi_rdata_i),
    .bus_wait_i (spi_wait_i), .bus_rvalid_i (spi_rvalid_i)
  );

  bridge_bus_master #(.AW(UA_W), .DW(UD_W)) uart_m_i (
    .clk, .rst_n,
    .req_i (u_req), .req_wr_i (u_req_wr), .req_addr_i (u_req_addr),
    .req_wdata_i (u_req_wdata), .done_o (u_done), .rdata_o (u_rdata),
    .bus_addr_o (uart_addr_o), .bus_rd_o (uart_rd_o), .bus_wr_o (uart_wr_o),
    .bus_wdata_o (uart_wdata_o), .bus_rdata_i (uart_rdata_i),
    .bus_wait_i (uart_wait_i), .bus_rvalid_i (uart_rvalid_i)
  );

  // Named events for the FSM and the assertions
  wire rx_ready   = spi_done && spi_rdata[RRDY_BIT];
  wire cmd_taken  = (state == ST_FETCH) && spi_done;
  wire lsr_ready  = u_rdata[DR_BIT];
  wire [UD_W-1:0] flags_payload = UD_W'(port_avail_i);

  // Bus requests per state
  always_comb begin
    spi_req      = 1'b0;
    spi_req_wr   = 1'b0;
    spi_req_addr = SPI_ST_OFS;
    u_req        = 1'b0;
    u_req_wr     = 1'b0;
    u_req_addr   = dec_addr;
    u_req_wdata  = dec_data;
    unique case (state)
      ST_POLL:   spi_req = 1'b1;
      ST_FETCH:  begin spi_req = 1'b1; spi_req_addr = SPI_RX_OFS; end
      ST_SPIWR:  begin spi_req = 1'b1; spi_req_wr = 1'b1; spi_req_addr = SPI_TX_OFS; end
      ST_UWRITE: begin u_req = 1'b1; u_req_wr = 1'b1; end
      ST_UREAD:  u_req = 1'b1;
      ST_LSR:    begin u_req = 1'b1; u_req_addr = win_addr(dec_port, LSR_OFS); end
      ST_FIFO:   begin u_req = 1'b1; u_req_addr = win_addr(dec_port, RXD_OFS); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idle_cnt <= '0;
      cmd_q    <= '0;
      resp_q   <= '0;
      fifo_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (idle_cnt == IDLE_W'(IDLE_CYC - 1)) begin
            idle_cnt <= '0;
            state    <= ST_POLL;
          end else begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
        ST_POLL:  if (rx_ready) state <= ST_FETCH;
        ST_FETCH: if (cmd_taken) begin
          cmd_q <= spi_rdata;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          unique case (dec_kind)
            CMD_WRITE:  state <= ST_UWRITE;
            CMD_READ:   state <= ST_UREAD;
            CMD_STREAM: state <= ST_LSR;
            CMD_STATUS: begin resp_q <= frame_resp(flags_payload); state <= ST_SPIWR; end
            CMD_BAD:    begin resp_q <= frame_resp('0); state <= ST_SPIWR; end
            default:    state <= ST_IDLE;
          endcase
        end
        ST_UWRITE: if (u_done) state <= ST_IDLE;
        ST_UREAD:  if (u_done) begin
          resp_q <= frame_resp(u_rdata);
          state  <= ST_SPIWR;
        end
        ST_LSR: if (u_done) begin
          if (lsr_ready) state <= ST_FIFO;
          else begin
            resp_q <= frame_resp(stream_payload(1'b0, '0));
            state  <= ST_SPIWR;
          end
        end
        ST_FIFO: if (u_done) begin
          fifo_q <= u_rdata;
          state  <= ST_PACK;
        end
        ST_PACK: begin
          resp_q <= frame_resp(stream_payload(1'b1, fifo_q));
          state  <= ST_SPIWR;
        end
        ST_SPIWR: if (spi_done) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R1: no bus traffic while idling
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !(spi_rd_o || spi_wr_o || uart_rd_o || uart_wr_o));

  // R1: idle lasts two cycles before polling starts
  a_r1_idle_two: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state == ST_IDLE) |-> $past(state == ST_IDLE, 2));

  // R3: a write command never touches the SPI core
  a_r3_no_spi_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UWRITE) |-> !spi_wr_o);

  // R5: every response carries the lead code and zero pad bits
  a_r5_frame: assert property (@(posedge clk) disable iff (!rst_n)
    spi_wr_o |-> (spi_wdata_o[31:18] == LEAD_CODE && spi_wdata_o[1:0] == 2'b00));

  // R7: the receive register is read only after line status showed data
  a_r7_fifo_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_FIFO) |-> $past(uart_rvalid_i && uart_rdata_i[DR_BIT]));

  // R8: dummy command goes straight back to idle
  a_r8_dummy_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && dec_kind == CMD_DUMMY) |=> (state == ST_IDLE));

  // R10: undefined opcodes are dropped
  a_r10_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && dec_kind == CMD_NONE) |=> (state == ST_IDLE));
endmodule

// File: tb/spi_cmd_bridge_tb_top.sv
module spi_cmd_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // DUT ports
  logic [2:0]  spi_addr;
  logic        spi_rd, spi_wr;
  logic [31:0] spi_wdata;
  logic [31:0] spi_rdata = '0;
  logic        spi_wait, spi_rvalid = 1'b0;
  logic [11:0] u_addr;
  logic        u_rd, u_wr;
  logic [15:0] u_wdata;
  logic [15:0] u_rdata = '0;
  logic        u_wait, u_rvalid = 1'b0;
  logic [5:0]  avail = 6'b101001;

  spi_cmd_bridge dut_i (
    .clk, .rst_n,
    .spi_addr_o (spi_addr), .spi_rd_o (spi_rd), .spi_wr_o (spi_wr),
    .spi_wdata_o (spi_wdata), .spi_rdata_i (spi_rdata),
    .spi_wait_i (spi_wait), .spi_rvalid_i (spi_rvalid),
    .uart_addr_o (u_addr), .uart_rd_o (u_rd), .uart_wr_o (u_wr),
    .uart_wdata_o (u_wdata), .uart_rdata_i (u_rdata),
    .uart_wait_i (u_wait), .uart_rvalid_i (u_rvalid),
    .port_avail_i (avail)
  );

  // Slave models: optional one-cycle stall, read data one cycle after accept
  logic stall_en = 1'b0;
  logic spi_held = 1'b0, u_held = 1'b0;
  assign spi_wait = stall_en & (spi_rd | spi_wr) & ~spi_held;
  assign u_wait   = stall_en & (u_rd | u_wr) & ~u_held;

  int sent = 0, taken = 0;
  logic [31:0] cmd_word = '0;
  int tx_cnt = 0, st_reads = 0, rx_reads = 0;
  logic [31:0] tx_last = '0;
  int uwr_cnt = 0, urd_cnt = 0;
  logic [11:0] uwr_addr = '0;
  logic [15:0] uwr_data = '0;
  logic [15:0] uregs [0:4095];

  always @(posedge clk) begin
    spi_held   <= stall_en & (spi_rd | spi_wr) & ~spi_held;
    spi_rvalid <= 1'b0;
    if (spi_rd && !spi_wait) begin
      spi_rvalid <= 1'b1;
      if (spi_addr == 3'd0) begin
        spi_rdata <= cmd_word;
        taken     <= taken + 1;
        rx_reads  <= rx_reads + 1;
      end else if (spi_addr == 3'd2) begin
        spi_rdata <= {24'h0, (sent != taken), 7'h0};
        st_reads  <= st_reads + 1;
      end else spi_rdata <= '0;
    end
    if (spi_wr && !spi_wait && spi_addr == 3'd1) begin
      tx_cnt  <= tx_cnt + 1;
      tx_last <= spi_wdata;
    end
  end

  always @(posedge clk) begin
    u_held   <= stall_en & (u_rd | u_wr) & ~u_held;
    u_rvalid <= 1'b0;
    if (u_rd && !u_wait) begin
      u_rvalid <= 1'b1;
      u_rdata  <= uregs[u_addr];
      urd_cnt  <= urd_cnt + 1;
    end
    if (u_wr && !u_wait) begin
      uwr_cnt  <= uwr_cnt + 1;
      uwr_addr <= u_addr;
      uwr_data <= u_wdata;
    end
  end

  function automatic logic [31:0] framed(input logic [15:0] p);
    return {14'h2000, p, 2'b00};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Vector table: command, kind (0 silent, 1 response, 2 UART write), expected
  localparam int NV = 12;
  localparam logic [31:0] V_CMD [0:NV-1] = '{
    32'h43A2_1234, 32'h8204_0000, 32'h8000_00FF, 32'h8600_00FE,
    32'h8400_00FE, 32'h87FF_00FE, 32'h8204_0042, 32'h8204_00FD,
    32'h0204_1111, 32'hC3A2_5555, 32'h8204_AB00, 32'h4BFF_FFFF };
  localparam logic [1:0] V_KIND [0:NV-1] = '{
    2'd2, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2 };
  localparam logic [31:0] V_EXP [0:NV-1] = '{
    32'h03A2_1234, 32'h0000_BEEF, 32'h0000_0029, 32'h0000_9234,
    32'h0000_0000, 32'h0000_9234, 32'h0000_0000, 32'h0,
    32'h0, 32'h0, 32'h0000_BEEF, 32'h0BFF_FFFF };

  function automatic string vtag(input int i);
    case (i)
      0, 11: return "R3";
      1, 10: return "R4/R5";
      2:     return "R6/R5";
      3, 4, 5: return "R7/R5";
      6:     return "R9/R5";
      7:     return "R8";
      default: return "R10";
    endcase
  endfunction

  int b_tx, b_wr, b_rd, b_rx;
  task automatic issue(input logic [31:0] c);
    @(negedge clk);
    b_tx = tx_cnt; b_wr = uwr_cnt; b_rd = urd_cnt; b_rx = rx_reads;
    cmd_word = c;
    sent = sent + 1;
    repeat (60) @(negedge clk);
  endtask

  logic finished = 1'b0;

  initial begin
    for (int a = 0; a < 4096; a++) uregs[a] = 16'h0;
    uregs[12'h204] = 16'hBEEF;
    uregs[12'h614] = 16'h0001;
    uregs[12'h600] = 16'h1234;
    uregs[12'h414] = 16'h0000;
    uregs[12'h400] = 16'h7777;

    // R1: strobes low during reset
    repeat (3) @(negedge clk);
    check("R1 reset strobes", {28'h0, spi_rd, spi_wr, u_rd, u_wr}, 32'h0);
    rst_n = 1'b1;

    // R1: polling with nothing pending never fetches
    repeat (30) @(negedge clk);
    check("R1 polling active", 32'(st_reads > 0), 32'h1);
    check("R1 no fetch without rrdy", 32'(rx_reads), 32'h0);

    for (int i = 0; i < NV; i++) begin
      stall_en = i[0];
      issue(V_CMD[i]);
      check({vtag(i), " fetch once"}, 32'(rx_reads - b_rx), 32'h1);
      case (V_KIND[i])
        2'd2: begin
          check({vtag(i), " write count"}, 32'(uwr_cnt - b_wr), 32'h1);
          check({vtag(i), " write addr/data"}, {4'h0, uwr_addr, uwr_data}, V_EXP[i]);
          check({vtag(i), " no response"}, 32'(tx_cnt - b_tx), 32'h0);
        end
        2'd1: begin
          check({vtag(i), " response count"}, 32'(tx_cnt - b_tx), 32'h1);
          check({vtag(i), " response word"}, tx_last, framed(V_EXP[i][15:0]));
          check({vtag(i), " no UART write"}, 32'(uwr_cnt - b_wr), 32'h0);
        end
        default: begin
          check({vtag(i), " silent SPI"}, 32'(tx_cnt - b_tx), 32'h0);
          check({vtag(i), " silent UART"}, 32'(uwr_cnt - b_wr + urd_cnt - b_rd), 32'h0);
        end
      endcase
    end

    // R7: empty FIFO costs one UART read, data present costs two
    stall_en = 1'b1;
    issue(32'h8400_00FE);
    check("R7 empty reads line status only", 32'(urd_cnt - b_rd), 32'h1);
    issue(32'h8600_00FE);
    check("R7 ready reads status and data", 32'(urd_cnt - b_rd), 32'h2);
    // R8: dummy leaves the last response untouched
    issue(32'h8204_00FD);
    check("R8 dummy keeps response", tx_last, framed(16'h9234));
    // R6: flags follow the inputs
    avail = 6'b010110;
    issue(32'h8000_00FF);
    check("R6 flags changed", tx_last, framed(16'h0016));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule